// File: doc/BRIEF.md
# Dual-Function Nine-Pin Port Controller

This block is a memory-mapped I/O port with nine pins. Each pin either works as a plain parallel pin under software control, or is handed to a serial peripheral that sits next to the port. Pins 0 to 2 belong to an asynchronous serial interface, which uses them for receive, transmit and serial clock. Pins 3 to 8 belong to a synchronous serial interface. The serial peripherals are outside this block. The port only routes their output value and output enable to the pad, and hands the pad's input value back to them.

Software sees three 24-bit registers at fixed data-memory addresses. A function-select register picks, for each pin, parallel or serial use. A direction register sets whether each parallel pin drives or listens. A pin-data register returns the synchronised pad levels when read, and sets the output levels of the parallel pins when written. Bus writes take effect at the clock edge where the write strobe is sampled. Read data is registered and appears in the cycle after the read strobe.

Top module: `dualfn_port`

## Requirements
- R1: After reset the function-select, direction and output-level registers are all zero. Every pin is therefore a parallel input: pinOe is 0, pinOut is 0, and busRdata is 0.
- R2: The function-select register is at address 0xFFE1. Bit i set to 1 gives pin i to its serial peripheral, and 0 keeps it parallel. A read strobe sampled at edge k puts the addressed register on busRdata from edge k up to edge k+1. In a cycle after an edge without a read strobe, busRdata is 0.
- R3: The direction register is at address 0xFFE3. For a parallel pin, direction bit 1 drives the pin (pinOe = 1) and 0 makes it an input (pinOe = 0). A write takes effect from the edge that samples it.
- R4: A write to the pin-data address 0xFFE5 stores bits 8:0 as output levels. From the sampling edge, each parallel pin shows its stored level on pinOut.
- R5: A read of 0xFFE5 returns pinIn after a two-flop synchroniser. A read strobe sampled two edges after the edge that first samples a new pinIn value returns that value. A read strobe sampled one edge after it still returns the previous value.
- R6: For a pin in serial mode, pinOut equals perOut and pinOe equals perOe for that pin.
- R7: While a pin is in serial mode, its direction and output-level bits have no effect on the pin. They keep their values, and writes to them are still stored. When the pin returns to parallel mode, it uses the stored values.
- R8: perIn carries the synchronised pad level for pins in serial mode and is 0 for pins in parallel mode.
- R9: Register bits 23:9 read as 0 and writes to them are discarded. A read of any other address returns 0, and a write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Bus word address |
| busRd | input | 1 | Read strobe, sampled at the rising edge |
| busWr | input | 1 | Write strobe, sampled at the rising edge |
| busWdata | input | 24 | Write data |
| busRdata | output | 24 | Registered read data, valid the cycle after the read strobe |
| pinIn | input | 9 | Pad input levels (asynchronous) |
| pinOut | output | 9 | Pad output levels |
| pinOe | output | 9 | Pad output enables, 1 = drive |
| perOut | input | 9 | Output levels from the serial peripherals |
| perOe | input | 9 | Output enables from the serial peripherals |
| perIn | output | 9 | Synchronised pad levels returned to the serial peripherals |

## Verification
Register writes change pinOut and pinOe at the same edge that samples the write. The bench therefore checks them just after that edge. Read data is due exactly one edge after the read strobe and is checked just after that edge. One further edge later it is checked again and must be zero. A pinIn change is due in a read strobe sampled two edges after the change is first sampled, and perIn follows it on the same two-edge delay. The bench reads once at one edge to see the old value and once at two edges to see the new one, and it waits at least three edges before it checks perIn. All stimulus is driven on the falling edge, and all sampling happens one time unit after the rising edge.

// File: rtl/dualfn_port_pkg.sv
package dualfn_port_pkg;

  // Which register the read path returns in the next cycle
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FUNC = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_PIN  = 2'd3
  } rdSel_e;

  // Strobes sent from the decode logic to the datapath
  typedef struct packed {
    logic   wrFunc;
    logic   wrDir;
    logic   wrLatch;
    rdSel_e rdSel;
  } portStrobe_t;

endpackage

// File: rtl/dualfn_port_ctrl.sv
module dualfn_port_ctrl
  import dualfn_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] FUNC_ADDR = 16'hFFE1,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFFE3,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 16'hFFE5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output portStrobe_t       strobe
);

  logic hitFunc;
  logic hitDir;
  logic hitPin;

  assign hitFunc = (busAddr == FUNC_ADDR);
  assign hitDir  = (busAddr == DIR_ADDR);
  assign hitPin  = (busAddr == PIN_ADDR);

  always_comb begin
    strobe.wrFunc  = busWr & hitFunc;
    strobe.wrDir   = busWr & hitDir;
    strobe.wrLatch = busWr & hitPin;
    strobe.rdSel   = SEL_NONE;
    if (busRd) begin
      if (hitFunc)     strobe.rdSel = SEL_FUNC;
      else if (hitDir) strobe.rdSel = SEL_DIR;
      else if (hitPin) strobe.rdSel = SEL_PIN;
    end
  end

endmodule

// File: rtl/dualfn_port_dp.sv
module dualfn_port_dp
  import dualfn_port_pkg::*;
#(
  parameter int NUM_PINS    = 9,
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobe_t         strobe,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  input  logic [NUM_PINS-1:0] perOut,
  input  logic [NUM_PINS-1:0] perOe,
  output logic [NUM_PINS-1:0] perIn,
  output logic [NUM_PINS-1:0] funcReg,
  output logic [NUM_PINS-1:0] dirReg,
  output logic [NUM_PINS-1:0] latchReg
);

  localparam int PAD_W = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] wLow;
  logic                unusedHi;
  logic [NUM_PINS-1:0] pinState;
  logic [NUM_PINS-1:0] rdSel;
  logic [DATA_W-1:0]   rdNext;

  assign wLow     = wdata[NUM_PINS-1:0];
  assign unusedHi = ^wdata[DATA_W-1:NUM_PINS];

  // Software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      funcReg  <= '0;
      dirReg   <= '0;
      latchReg <= '0;
    end else begin
      if (strobe.wrFunc)  funcReg  <= wLow;
      if (strobe.wrDir)   dirReg   <= wLow;
      if (strobe.wrLatch) latchReg <= wLow;
    end
  end

  // Input synchroniser; the stage count picks the shift form
  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinIn;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      end
    end
  endgenerate

  assign pinState = syncQ[SYNC_STAGES-1];

  // Read path
  always_comb begin
    case (strobe.rdSel)
      SEL_FUNC: rdSel = funcReg;
      SEL_DIR:  rdSel = dirReg;
      SEL_PIN:  rdSel = pinState;
      default:  rdSel = '0;
    endcase
    rdNext = {{PAD_W{1'b0}}, rdSel};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdata <= '0;
    else       rdata <= rdNext;
  end

  // Per-pin function steering
  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign pinOut[p] = funcReg[p] ? perOut[p] : latchReg[p];
      assign pinOe[p]  = funcReg[p] ? perOe[p]  : dirReg[p];
      assign perIn[p]  = funcReg[p] & pinState[p];
    end
  endgenerate

endmodule

// File: rtl/dualfn_port.sv
module dualfn_port
  import dualfn_port_pkg::*;
#(
  parameter int NUM_PINS    = 9,
  parameter int DATA_W      = 24,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] FUNC_ADDR = 16'hFFE1,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFFE3,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 16'hFFE5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  input  logic [NUM_PINS-1:0] perOut,
  input  logic [NUM_PINS-1:0] perOe,
  output logic [NUM_PINS-1:0] perIn
);

  portStrobe_t         strobe;
  logic [NUM_PINS-1:0] funcReg;
  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] latchReg;

  dualfn_port_ctrl #(
    .ADDR_W   (ADDR_W),
    .FUNC_ADDR(FUNC_ADDR),
    .DIR_ADDR (DIR_ADDR),
    .PIN_ADDR (PIN_ADDR)
  ) uCtrl (
    .busAddr(busAddr),
    .busRd  (busRd),
    .busWr  (busWr),
    .strobe (strobe)
  );

  dualfn_port_dp #(
    .NUM_PINS   (NUM_PINS),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .perOut  (perOut),
    .perOe   (perOe),
    .perIn   (perIn),
    .funcReg (funcReg),
    .dirReg  (dirReg),
    .latchReg(latchReg)
  );

endmodule

// File: rtl/dualfn_port_chk.sv
module dualfn_port_chk #(
  parameter int NUM_PINS = 9,
  parameter int DATA_W   = 24,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] FUNC_ADDR = 16'hFFE1,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFFE3,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 16'hFFE5
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busRd,
  input logic                busWr,
  input logic [NUM_PINS-1:0] busWdataLo,
  input logic [DATA_W-1:0]   busRdata,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [NUM_PINS-1:0] funcReg,
  input logic [NUM_PINS-1:0] dirReg
);

  logic unmapped;
  assign unmapped = (busAddr != FUNC_ADDR) && (busAddr != DIR_ADDR) &&
                    (busAddr != PIN_ADDR);

  // R2: no read strobe, nothing on the read bus next cycle
  assert_quiet_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> (busRdata == '0));

  // R2: function-select readback one cycle after the strobe
  assert_func_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == FUNC_ADDR && !busWr) |=>
      (busRdata[NUM_PINS-1:0] == $past(funcReg)));

  // R3: direction write drives parallel pins' enables
  assert_dir_drive_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == DIR_ADDR) |=>
      ((pinOe & ~funcReg) == ($past(busWdataLo) & ~funcReg)));

  // R4: level write appears on parallel pins
  assert_level_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == PIN_ADDR) |=>
      ((pinOut & ~funcReg) == ($past(busWdataLo) & ~funcReg)));

  // R7: direction bits only change through their own write
  assert_dir_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == DIR_ADDR) |=> $stable(dirReg));

  // R9: unmapped reads return zero
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && unmapped) |=> (busRdata == '0));

  // R9: upper read bits always zero
  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:NUM_PINS] == '0);

endmodule

bind dualfn_port dualfn_port_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .FUNC_ADDR(FUNC_ADDR),
  .DIR_ADDR (DIR_ADDR),
  .PIN_ADDR (PIN_ADDR)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRd     (busRd),
  .busWr     (busWr),
  .busWdataLo(busWdata[NUM_PINS-1:0]),
  .busRdata  (busRdata),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .funcReg   (funcReg),
  .dirReg    (dirReg)
);

// File: tb/sim_dualfn_port.sv
module sim_dualfn_port;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_FUNC = 16'hFFE1;
  localparam logic [15:0] A_DIR  = 16'hFFE3;
  localparam logic [15:0] A_PIN  = 16'hFFE5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [23:0] busWdata = '0;
  logic [23:0] busRdata;
  logic [8:0]  pinIn = '0;
  logic [8:0]  pinOut;
  logic [8:0]  pinOe;
  logic [8:0]  perOut = '0;
  logic [8:0]  perOe = '0;
  logic [8:0]  perIn;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualfn_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .perOut(perOut), .perOe(perOe), .perIn(perIn)
  );

  task automatic check(input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [23:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [23:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(posedge clk); #1;
    d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [23:0] d;
    check("R1", "pinOe after reset", {15'd0, pinOe}, 24'h0);
    check("R1", "pinOut after reset", {15'd0, pinOut}, 24'h0);
    check("R1", "busRdata after reset", busRdata, 24'h0);
    busRead(A_FUNC, d); check("R1", "function reg reset", d, 24'h0);
    busRead(A_DIR, d);  check("R1", "direction reg reset", d, 24'h0);
  endtask

  task automatic t_func_readback;
    logic [23:0] d;
    busWrite(A_FUNC, 24'h0001A5);
    busRead(A_FUNC, d); check("R2", "function readback", d, 24'h0001A5);
    waitEdges(1); check("R2", "read bus idle after read", busRdata, 24'h0);
    busWrite(A_FUNC, 24'hFFFFFF);
    busRead(A_FUNC, d); check("R9", "upper bits dropped", d, 24'h0001FF);
    busWrite(A_FUNC, 24'h0);
  endtask

  task automatic t_direction;
    logic [23:0] d;
    busWrite(A_DIR, 24'h0000F0);
    check("R3", "pinOe follows direction", {15'd0, pinOe}, 24'h0000F0);
    busRead(A_DIR, d); check("R3", "direction readback", d, 24'h0000F0);
  endtask

  task automatic t_levels;
    busWrite(A_PIN, 24'h000155);
    check("R4", "pinOut after level write", {15'd0, pinOut}, 24'h000155);
    busWrite(A_PIN, 24'h0000AA);
    check("R4", "pinOut after second write", {15'd0, pinOut}, 24'h0000AA);
  endtask

  task automatic t_sync;
    logic [23:0] d;
    @(negedge clk); pinIn = 9'h0AB;
    busRead(A_PIN, d); check("R5", "read one edge after change", d, 24'h0);
    busRead(A_PIN, d); check("R5", "read two edges after change", d, 24'h0000AB);
    @(negedge clk); pinIn = 9'h154;
    waitEdges(3);
    busRead(A_PIN, d); check("R5", "settled pin read", d, 24'h000154);
  endtask

  task automatic t_serial;
    // levels 0x0AA, direction 0x0F0 from earlier tasks
    perOut = 9'h005; perOe = 9'h00A;
    busWrite(A_FUNC, 24'h00000F);
    check("R6", "pinOut mixed modes", {15'd0, pinOut}, 24'h0000A5);
    check("R6", "pinOe mixed modes", {15'd0, pinOe}, 24'h0000FA);
    @(negedge clk); perOut = 9'h00A; perOe = 9'h005;
    #1; check("R6", "pinOut tracks peripheral", {15'd0, pinOut}, 24'h0000AA);
  endtask

  task automatic t_retain;
    logic [23:0] d;
    busWrite(A_DIR, 24'h0001FF);
    busWrite(A_PIN, 24'h000000);
    check("R7", "serial pins ignore new levels", {15'd0, pinOut}, 24'h00000A);
    check("R7", "serial pins ignore new direction", {15'd0, pinOe}, 24'h0001F5);
    busWrite(A_FUNC, 24'h0);
    check("R7", "stored direction used after return", {15'd0, pinOe}, 24'h0001FF);
    check("R7", "stored level used after return", {15'd0, pinOut}, 24'h0);
    busRead(A_DIR, d); check("R7", "direction kept", d, 24'h0001FF);
  endtask

  task automatic t_per_in;
    busWrite(A_FUNC, 24'h00000F);
    @(negedge clk); pinIn = 9'h1F3;
    waitEdges(3);
    check("R8", "perIn gated by mode", {15'd0, perIn}, 24'h000003);
    busWrite(A_FUNC, 24'h0);
    check("R8", "perIn zero in parallel", {15'd0, perIn}, 24'h0);
  endtask

  task automatic t_unmapped;
    logic [23:0] d;
    busWrite(16'hFFE2, 24'h0001FF);
    busWrite(16'hFFE4, 24'h000000);
    busRead(16'hFFE2, d); check("R9", "unmapped read", d, 24'h0);
    busRead(16'h0000, d); check("R9", "low unmapped read", d, 24'h0);
    busRead(A_FUNC, d); check("R9", "function untouched", d, 24'h0);
    busRead(A_DIR, d);  check("R9", "direction untouched", d, 24'h0001FF);
    check("R9", "levels untouched", {15'd0, pinOut}, 24'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    waitEdges(3);
    @(negedge clk); rstN = 1'b1;
    waitEdges(1);
    t_reset();
    t_func_readback();
    t_direction();
    t_levels();
    t_sync();
    t_serial();
    t_retain();
    t_per_in();
    t_unmapped();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule